// File: doc/BRIEF.md
# Non-Integer Ratio Stream Width Converter

This block carries a continuous data stream from an input port of IN_W bits to an output port of OUT_W bits. It also works when neither width is a whole multiple of the other. The conversion runs through an internal word whose width is the least common multiple of the two widths. A packing stage gathers consecutive input words into one wide word. An unpacking stage then slices each wide word into output words. The two stages work at the same time, so slicing of one wide word overlaps with gathering of the next.

When one width divides the other, the stage that would have a ratio of one becomes plain wiring, and only one conversion stage remains. A frame is FRAME_WORDS input words. This count must split evenly into wide words, and elaboration stops with an error when it does not. Frames follow one another with no start or done control. Both ports use a valid/ready handshake. A word moves on a clock edge where valid and ready are both high. A producer must keep its valid and data steady until the word is taken. The block keeps `out_valid` and `out_data` steady while `out_ready` is low. It lowers `in_ready` only when the packing stage has nowhere to put a completed wide word.

Top module: `ratio_width_conv`

## Requirements
- R1: The bits on the output equal the input bits in stream order. Stream bit 0 is bit 0 of the first input word after reset. Each input word adds IN_W bits above the previous ones. Each output word carries the next OUT_W stream bits, the lowest stream bit in out_data bit 0.
- R2: The internal word is lcm(IN_W, OUT_W) bits wide and packs lcm/IN_W consecutive input words, the earliest in the least significant bits. No output appears before a complete internal word has been gathered. A frame gives exactly FRAME_WORDS/(lcm/IN_W) internal words.
- R3: Every group of whole frames accepted gives exactly (words accepted)·IN_W/OUT_W output words, and no more.
- R4: FRAME_WORDS must be a multiple of lcm/IN_W, or elaboration fails. At every frame boundary the packing stage holds no partial word, so once a whole number of frames has drained, out_valid stays low.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_data keeps its value on the next cycle. The same holds for the internal hand-off between the stages.
- R6: With in_valid and out_ready held high, the block moves one word per cycle on the narrower-bandwidth side. If IN_W <= OUT_W, in_ready never drops. If IN_W > OUT_W, out_valid stays high from the first output word to the last.
- R7: A synchronous active-high reset clears both valid flags and both partial-word counters. Any partly gathered word is discarded. After reset out_valid is low and in_ready is high.
- R8: When one width is a multiple of the other, a single stage converts the stream with the same bit order and counts as R1 and R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block accepts the input word |
| in_data | input | IN_W | Input word |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | OUT_W | Output word |

## Verification
The block is tried at three width pairs. A 12-to-20 pair grows with a non-integer ratio. A 24-to-10 pair shrinks with a non-integer ratio. An 8-to-24 pair has an exact ratio. Each pair sees six valid/ready mask patterns: both sides free-running, a stalling consumer, a sparse producer, and bursty mixes of both. The free-running pattern separates a correct overlap of the stages from one that adds bubbles. The stalled patterns show whether held words stay steady and whether any word is lost or duplicated. A partial gather that is cut off by reset shows whether leftover bits leak into the next stream.

// File: rtl/wconv_pkg.sv
package wconv_pkg;

  function automatic int gcd_f(input int a, input int b);
    int x;
    int y;
    int t;
    x = a;
    y = b;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  function automatic int lcm_f(input int a, input int b);
    return (a / gcd_f(a, b)) * b;
  endfunction

endpackage

// File: rtl/width_pack.sv
module width_pack #(
  parameter int IN_W  = 12,
  parameter int MID_W = 60
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic             mid_valid,
  input  logic             mid_ready,
  output logic [MID_W-1:0] mid_data,
  output logic             empty_o
);
  localparam int N     = MID_W / IN_W;
  localparam int CW    = $clog2(N);
  localparam int ACC_W = MID_W - IN_W;

  logic [CW-1:0]    cnt;
  logic [ACC_W-1:0] acc;
  logic             hold_v;
  logic [MID_W-1:0] hold_d;
  logic             at_last;
  logic             take;

  assign at_last   = (cnt == CW'(N - 1));
  assign in_ready  = !at_last || !hold_v || mid_ready;
  assign take      = in_valid && in_ready;
  assign mid_valid = hold_v;
  assign mid_data  = hold_d;
  assign empty_o   = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      hold_v <= 1'b0;
    end else begin
      if (take) cnt <= at_last ? '0 : cnt + CW'(1);
      if (take && at_last) hold_v <= 1'b1;
      else if (mid_ready)  hold_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take && !at_last) begin
      for (int i = 0; i < N - 1; i++) begin
        if (cnt == CW'(i)) acc[i*IN_W +: IN_W] <= in_data;
      end
    end
    if (take && at_last) hold_d <= {in_data, acc};
  end

  AST_MID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (hold_v && !mid_ready) |=> (hold_v && $stable(hold_d))); // R5

endmodule

// File: rtl/width_unpack.sv
module width_unpack #(
  parameter int MID_W = 60,
  parameter int OUT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mid_valid,
  output logic             mid_ready,
  input  logic [MID_W-1:0] mid_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);
  localparam int N  = MID_W / OUT_W;
  localparam int CW = $clog2(N);

  logic [MID_W-1:0] sh;
  logic [CW-1:0]    idx;
  logic             uv;
  logic             fin;
  logic             load;
  logic             adv;

  assign fin       = (idx == CW'(N - 1));
  assign mid_ready = !uv || (fin && out_ready);
  assign load      = mid_valid && mid_ready;
  assign adv       = uv && out_ready;
  assign out_valid = uv;
  assign out_data  = sh[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      uv  <= 1'b0;
      idx <= '0;
    end else if (load) begin
      uv  <= 1'b1;
      idx <= '0;
    end else if (adv) begin
      if (fin) uv <= 1'b0;
      else     idx <= idx + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (load)     sh <= mid_data;
    else if (adv) sh <= sh >> OUT_W;
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (uv && !out_ready) |=> (uv && $stable(sh[OUT_W-1:0]))); // R5

endmodule

// File: rtl/ratio_width_conv.sv
module ratio_width_conv
  import wconv_pkg::*;
#(
  parameter int IN_W        = 12,
  parameter int OUT_W       = 20,
  parameter int FRAME_WORDS = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);
  localparam int MID_W     = lcm_f(IN_W, OUT_W);
  localparam int PACK_N    = MID_W / IN_W;
  localparam int UNPACK_N  = MID_W / OUT_W;
  localparam int MID_FRAME = FRAME_WORDS / PACK_N;
  localparam int PW        = $clog2(FRAME_WORDS + 1);
  localparam int MW        = $clog2(MID_FRAME + 1);

  logic             mid_valid;
  logic             mid_ready;
  logic [MID_W-1:0] mid_data;
  logic             pack_empty;

  if (FRAME_WORDS % PACK_N != 0) begin : g_bad_frame
    $error("frame length is not a whole number of internal words");
  end

  if (PACK_N > 1) begin : g_pack
    width_pack #(.IN_W(IN_W), .MID_W(MID_W)) u_pack (
      .clk(clk), .rst(rst),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .mid_valid(mid_valid), .mid_ready(mid_ready), .mid_data(mid_data),
      .empty_o(pack_empty)
    );
  end else begin : g_pack_wire
    assign mid_valid  = in_valid;
    assign in_ready   = mid_ready;
    assign mid_data   = in_data;
    assign pack_empty = 1'b1;
  end

  if (UNPACK_N > 1) begin : g_unpack
    width_unpack #(.MID_W(MID_W), .OUT_W(OUT_W)) u_unpack (
      .clk(clk), .rst(rst),
      .mid_valid(mid_valid), .mid_ready(mid_ready), .mid_data(mid_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );
  end else begin : g_unpack_wire
    assign out_valid = mid_valid;
    assign mid_ready = out_ready;
    assign out_data  = mid_data;
  end

  // frame position trackers used only by the checks below
  logic [PW-1:0] in_pos;
  logic [MW-1:0] mid_pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pos  <= '0;
      mid_pos <= '0;
    end else begin
      if (in_valid && in_ready)
        in_pos <= (in_pos == PW'(FRAME_WORDS - 1)) ? '0 : in_pos + PW'(1);
      if (mid_valid && mid_ready)
        mid_pos <= (mid_pos == MW'(MID_FRAME - 1)) ? '0 : mid_pos + MW'(1);
    end
  end

  AST_FRAME_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (in_pos == '0) |-> pack_empty); // R4

  AST_MID_PER_FRAME: assert property (@(posedge clk) disable iff (rst)
    ((in_pos == '0) && !mid_valid) |-> (mid_pos == '0)); // R2

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !out_valid); // R7

endmodule

// File: tb/test_ratio_width_conv.sv
module conv_harness #(
  parameter int IW         = 12,
  parameter int OW         = 20,
  parameter int FW         = 10,
  parameter int RF         = 2,
  parameter int CLK_PERIOD = 10
) (
  input  logic clk,
  output logic done,
  output int   n_chk,
  output int   n_bad
);
  localparam int  LCMW     = wconv_pkg::lcm_f(IW, OW);
  localparam int  PACK_N   = LCMW / IW;
  localparam int  PHASE_IN = FW * RF;
  localparam int  PHASE_OUT = PHASE_IN * IW / OW;
  localparam bit  DIRECT   = (IW % OW == 0) || (OW % IW == 0);
  // upper half: input valid mask, lower half: output ready mask
  localparam logic [31:0] PATTERNS [0:5] = '{
    32'hFFFF_FFFF, 32'hFFFF_5555, 32'h5555_FFFF,
    32'h00FF_F0F0, 32'h1111_FFFF, 32'hFFFF_1111
  };

  logic          rst;
  logic          in_valid;
  logic          in_ready;
  logic [IW-1:0] in_data;
  logic          out_valid;
  logic          out_ready;
  logic [OW-1:0] out_data;

  ratio_width_conv #(.IN_W(IW), .OUT_W(OW), .FRAME_WORDS(FW)) i_ratio_width_conv (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  string dtag;
  initial dtag = DIRECT ? "R8" : "R1";

  function automatic logic [31:0] word_at(input int seed, input int i);
    logic [31:0] x;
    x = 32'(i + seed * 1000) * 32'h9E37_79B1;
    return x ^ (x >> 13);
  endfunction

  function automatic logic [OW-1:0] exp_out(input int seed, input int j);
    logic [OW-1:0] r;
    logic [31:0]   w;
    int            g;
    for (int b = 0; b < OW; b++) begin
      g = j * OW + b;
      w = word_at(seed, g / IW);
      r[b] = w[g % IW];
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s (%0dx%0d): actual %0h expected %0h", tag, what, IW, OW, act, exp);
    end
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #(CLK_PERIOD / 4);
    chk(!out_valid, "R7", "out_valid after reset", 64'(out_valid), 64'd0);
    chk(in_ready, "R7", "in_ready after reset", 64'(in_ready), 64'd1);
  endtask

  task automatic run_phase(input int seed, input logic [15:0] imask,
                           input logic [15:0] omask, input bit full);
    int sent = 0;
    int got = 0;
    int cyc = 0;
    int stalls = 0;
    int gaps = 0;
    bit seen = 0;
    bit prev_stall = 0;
    logic [OW-1:0] prev_data = '0;
    logic [31:0] w;
    logic [OW-1:0] e;
    while ((sent < PHASE_IN || got < PHASE_OUT) && cyc < 4000) begin
      @(negedge clk);
      w = word_at(seed, sent);
      in_valid  = (sent < PHASE_IN) && imask[cyc % 16];
      in_data   = w[IW-1:0];
      out_ready = omask[cyc % 16];
      #(CLK_PERIOD / 4);
      if (prev_stall)
        chk(out_valid && (out_data == prev_data), "R5", "held word changed",
            64'(out_data), 64'(prev_data));
      if (full && IW <= OW && in_valid && !in_ready) stalls++;
      if (full && IW > OW && seen && got < PHASE_OUT && !out_valid) gaps++;
      if (out_valid && out_ready) begin
        if (got >= PHASE_OUT) begin
          chk(1'b0, "R3", "extra output word", 64'(got + 1), 64'(PHASE_OUT));
        end else begin
          e = exp_out(seed, got);
          chk(out_data == e, dtag, "output word", 64'(out_data), 64'(e));
        end
        got++;
        seen = 1;
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (in_valid && in_ready) sent++;
      cyc++;
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    chk(got == PHASE_OUT, "R3", "output word count", 64'(got), 64'(PHASE_OUT));
    if (full && IW <= OW)
      chk(stalls == 0, "R6", "input stalls at full rate", 64'(stalls), 64'd0);
    if (full && IW > OW)
      chk(gaps == 0, "R6", "output gaps at full rate", 64'(gaps), 64'd0);
    repeat (4) @(negedge clk);
    #(CLK_PERIOD / 4);
    chk(!out_valid, "R4", "output idle at frame boundary", 64'(out_valid), 64'd0);
  endtask

  initial begin
    done = 1'b0; n_chk = 0; n_bad = 0;
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
    pulse_reset();

    // walk the valid/ready pattern table
    for (int e = 0; e < 6; e++)
      run_phase(e, PATTERNS[e][31:16], PATTERNS[e][15:0], e == 0);

    // partial gather: no output until a whole internal word exists, then reset drops it
    @(negedge clk);
    out_ready = 1'b1;
    for (int k = 0; k < PACK_N - 1; k++) begin
      in_valid = 1'b1;
      in_data  = IW'(32'hFFFF_FFFF);
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    #(CLK_PERIOD / 4);
    chk(!out_valid, "R2", "output before full internal word", 64'(out_valid), 64'd0);
    pulse_reset();
    // fresh stream after reset must match from stream bit 0 (R7)
    run_phase(77, 16'hFFFF, 16'hFFFF, 1'b0);

    done = 1'b1;
  end
endmodule

module test_ratio_width_conv;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic d_up, d_dn, d_dir;
  int   c_up, c_dn, c_dir;
  int   b_up, b_dn, b_dir;

  conv_harness #(.IW(12), .OW(20), .FW(10), .RF(2), .CLK_PERIOD(CLK_PERIOD)) h_up (
    .clk(clk), .done(d_up), .n_chk(c_up), .n_bad(b_up));
  conv_harness #(.IW(24), .OW(10), .FW(10), .RF(2), .CLK_PERIOD(CLK_PERIOD)) h_dn (
    .clk(clk), .done(d_dn), .n_chk(c_dn), .n_bad(b_dn));
  conv_harness #(.IW(8), .OW(24), .FW(6), .RF(2), .CLK_PERIOD(CLK_PERIOD)) h_dir (
    .clk(clk), .done(d_dir), .n_chk(c_dir), .n_bad(b_dir));

  initial begin
    int cycles = 0;
    int total;
    int bad;
    while (!(d_up === 1'b1 && d_dn === 1'b1 && d_dir === 1'b1) && cycles < 100000) begin
      @(negedge clk);
      cycles++;
    end
    total = c_up + c_dn + c_dir;
    bad   = b_up + b_dn + b_dir;
    if (cycles >= 100000) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog expired: actual %0d cycles expected completion", cycles);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end
endmodule